// File: doc/BRIEF.md
# Accumulator ALU with Compare Flag

This block is the combinational arithmetic unit of a small accumulator machine. It takes the accumulator value and one second operand and returns an 8-bit result and a one-bit comparison flag. The core outside the block picks the second operand, which is either a register value or an unsigned constant taken from the instruction. The core also stores the result and the flag.

A 4-bit operation code selects the work. A decoder turns the code into a small set of steering strobes. The datapath holds four paths:
- an adder/subtractor,
- a bitwise logic unit,
- a path that rotates by one bit or passes an operand through unchanged,
- an unsigned magnitude comparator.

An output multiplexer picks the path that drives the result. Comparisons drive only the flag. During a comparison the result carries the accumulator unchanged, so the core can always write the result back without side effects.

Operation codes: 0 pass B, 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 invert accumulator, 7 rotate left, 8 rotate right, 9 equal, 10 less, 11 less-or-equal, 12 greater, 13 greater-or-equal. Codes 14 and 15 are unused.

Top module: `accum_alu`

## Requirements
- R1: Code 1 gives result = (acc + B) mod 256.
- R2: Code 2 gives result = (acc - B) mod 256.
- R3: Code 3 gives acc & B, code 4 gives acc | B, and code 5 gives acc ^ B.
- R4: Code 6 gives the bitwise complement of acc, and B has no effect on it.
- R5: Code 7 rotates acc left by one bit, so bit 7 moves to bit 0. Code 8 rotates acc right by one bit, so bit 0 moves to bit 7.
- R6: Code 0 passes B to the result unchanged.
- R7: Codes 9 to 13 set the flag to the truth of acc==B, acc<B, acc<=B, acc>B and acc>=B in that order. Both operands are treated as unsigned.
- R8: For codes 9 to 13 the result equals acc.
- R9: For every code other than 9 to 13 the flag is 0.
- R10: Codes 14 and 15 pass B to the result and hold the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accIn | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand (register or unsigned constant) |
| opSel | input | 4 | Operation code |
| result | output | 8 | Selected path output |
| flag | output | 1 | Comparison outcome, 0 for non-compare codes |

## Verification
Immediate assertions run on every input change. They check the following relations for whatever operands arrive:
- add and subtract wrap modulo 256,
- a comparison leaves the result equal to the accumulator,
- the unused codes pass B with a clear flag,
- no non-compare code raises the flag.

Only the bench scenarios can show that each logic and rotate code gives the right bit pattern. They also show that each of the five comparisons matches unsigned ordering at the equal, below and above boundaries, including operands that are above 127.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_AND = 4'd3,
    OP_OR   = 4'd4,  OP_XOR = 4'd5,  OP_NOT = 4'd6,  OP_ROL = 4'd7,
    OP_ROR  = 4'd8,  OP_EQ  = 4'd9,  OP_LT  = 4'd10, OP_LE  = 4'd11,
    OP_GT   = 4'd12, OP_GE  = 4'd13
  } op_e;

  typedef enum logic [1:0] {PATH_ARITH, PATH_LOGIC, PATH_SHIFT} path_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_INV} logic_e;
  typedef enum logic [1:0] {SH_PASSB, SH_PASSA, SH_ROL, SH_ROR} shift_e;
  typedef enum logic [2:0] {CMP_EQ, CMP_LT, CMP_LE, CMP_GT, CMP_GE} cmp_e;

  typedef struct packed {
    path_e  path;
    logic   subtract;
    logic_e logicOp;
    shift_e shiftMode;
    logic   cmpEn;
    cmp_e   cmpKind;
  } alu_ctrl_t;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import accum_alu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opSel,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl = '{path: PATH_SHIFT, subtract: 1'b0, logicOp: LG_AND,
             shiftMode: SH_PASSB, cmpEn: 1'b0, cmpKind: CMP_EQ};
    case (opSel)
      OP_ADD: ctrl.path = PATH_ARITH;
      OP_SUB: begin ctrl.path = PATH_ARITH; ctrl.subtract = 1'b1; end
      OP_AND: begin ctrl.path = PATH_LOGIC; ctrl.logicOp = LG_AND; end
      OP_OR:  begin ctrl.path = PATH_LOGIC; ctrl.logicOp = LG_OR;  end
      OP_XOR: begin ctrl.path = PATH_LOGIC; ctrl.logicOp = LG_XOR; end
      OP_NOT: begin ctrl.path = PATH_LOGIC; ctrl.logicOp = LG_INV; end
      OP_ROL: ctrl.shiftMode = SH_ROL;
      OP_ROR: ctrl.shiftMode = SH_ROR;
      OP_EQ:  begin ctrl.shiftMode = SH_PASSA; ctrl.cmpEn = 1'b1; ctrl.cmpKind = CMP_EQ; end
      OP_LT:  begin ctrl.shiftMode = SH_PASSA; ctrl.cmpEn = 1'b1; ctrl.cmpKind = CMP_LT; end
      OP_LE:  begin ctrl.shiftMode = SH_PASSA; ctrl.cmpEn = 1'b1; ctrl.cmpKind = CMP_LE; end
      OP_GT:  begin ctrl.shiftMode = SH_PASSA; ctrl.cmpEn = 1'b1; ctrl.cmpKind = CMP_GT; end
      OP_GE:  begin ctrl.shiftMode = SH_PASSA; ctrl.cmpEn = 1'b1; ctrl.cmpKind = CMP_GE; end
      default: ;
    endcase
  end

endmodule

// File: rtl/accum_alu_dp.sv
module accum_alu_dp
  import accum_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] opB,
  input  alu_ctrl_t    ctrl,
  output logic [W-1:0] result,
  output logic         flag
);

  logic [W-1:0] arithOut, logicOut, shiftOut;
  logic         isEq, isLt, cmpHit;

  assign arithOut = ctrl.subtract ? (accIn - opB) : (accIn + opB);

  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicOut = accIn & opB;
      LG_OR:   logicOut = accIn | opB;
      LG_XOR:  logicOut = accIn ^ opB;
      default: logicOut = ~accIn;
    endcase
  end

  always_comb begin
    case (ctrl.shiftMode)
      SH_PASSA: shiftOut = accIn;
      SH_ROL:   shiftOut = {accIn[W-2:0], accIn[W-1]};
      SH_ROR:   shiftOut = {accIn[0], accIn[W-1:1]};
      default:  shiftOut = opB;
    endcase
  end

  assign isEq = (accIn == opB);
  assign isLt = (accIn < opB);

  always_comb begin
    case (ctrl.cmpKind)
      CMP_EQ:  cmpHit = isEq;
      CMP_LT:  cmpHit = isLt;
      CMP_LE:  cmpHit = isLt | isEq;
      CMP_GT:  cmpHit = ~(isLt | isEq);
      CMP_GE:  cmpHit = ~isLt;
      default: cmpHit = 1'b0;
    endcase
  end

  assign flag = ctrl.cmpEn & cmpHit;

  always_comb begin
    case (ctrl.path)
      PATH_ARITH: result = arithOut;
      PATH_LOGIC: result = logicOut;
      default:    result = shiftOut;
    endcase
  end

  // R9: the flag stays low while the decoder leaves compare disabled
  always_comb begin
    if (!ctrl.cmpEn) p_flag_gated_r9: assert (!flag);
  end

  // R8: a compare strobe must never steer the arithmetic or logic path
  always_comb begin
    if (ctrl.cmpEn) p_cmp_path_r8: assert (result == accIn);
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int W    = 8,
  parameter int OP_W = 4
) (
  input  logic [W-1:0]    accIn,
  input  logic [W-1:0]    opB,
  input  logic [OP_W-1:0] opSel,
  output logic [W-1:0]    result,
  output logic            flag
);

  localparam logic [OP_W-1:0] FIRST_CMP = OP_W'(OP_EQ);
  localparam logic [OP_W-1:0] LAST_CMP  = OP_W'(OP_GE);

  alu_ctrl_t ctrl;
  logic      isCmpCode;

  accum_alu_ctrl #(.OP_W(OP_W)) u_ctrl (.opSel(opSel), .ctrl(ctrl));

  accum_alu_dp #(.W(W)) u_dp (
    .accIn(accIn), .opB(opB), .ctrl(ctrl), .result(result), .flag(flag)
  );

  assign isCmpCode = (opSel >= FIRST_CMP) && (opSel <= LAST_CMP);

  always_comb begin
    if (opSel == OP_W'(OP_ADD)) p_add_wrap_r1: assert (result == W'(accIn + opB));
    if (opSel == OP_W'(OP_SUB)) p_sub_wrap_r2: assert (result == W'(accIn - opB));
    if (isCmpCode)              p_cmp_keep_r8: assert (result == accIn);
    if (!isCmpCode)             p_flag_only_cmp_r9: assert (!flag);
    if (opSel > LAST_CMP)       p_unused_pass_r10: assert (result == opB && !flag);
  end

endmodule

// File: tb/accum_alu_bench.sv
module accum_alu_bench;

  logic       clk = 1'b0;
  logic [7:0] accIn = 8'd0, opB = 8'd0;
  logic [3:0] opSel = 4'd0;
  logic [7:0] result;
  logic       flag;
  int         nChecks = 0, nFails = 0;
  int         cycles = 0;

  always #5 clk = ~clk;

  accum_alu u_accum_alu (.accIn(accIn), .opB(opB), .opSel(opSel), .result(result), .flag(flag));

  task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    opSel = op; accIn = a; opB = b;
    #2;
  endtask

  task automatic testInitial();
    #2;
    check("R6 initial pass", {flag, result}, 9'h000);
  endtask

  task automatic testAddSub();
    apply(4'd1, 8'd200, 8'd100);  check("R1 add wrap",  {flag, result}, {1'b0, 8'd44});
    apply(4'd1, 8'd17,  8'd25);   check("R1 add",       {flag, result}, {1'b0, 8'd42});
    apply(4'd2, 8'd5,   8'd10);   check("R2 sub wrap",  {flag, result}, {1'b0, 8'd251});
    apply(4'd2, 8'd90,  8'd33);   check("R2 sub",       {flag, result}, {1'b0, 8'd57});
  endtask

  task automatic testLogic();
    apply(4'd3, 8'hCA, 8'h5F); check("R3 and", {flag, result}, {1'b0, 8'hCA & 8'h5F});
    apply(4'd4, 8'hCA, 8'h15); check("R3 or",  {flag, result}, {1'b0, 8'hCA | 8'h15});
    apply(4'd5, 8'hCA, 8'hFF); check("R3 xor", {flag, result}, {1'b0, 8'h35});
    apply(4'd6, 8'h3C, 8'h00); check("R4 not", {flag, result}, {1'b0, 8'hC3});
    apply(4'd6, 8'h3C, 8'hA5); check("R4 not ignores B", {flag, result}, {1'b0, 8'hC3});
  endtask

  task automatic testRotate();
    apply(4'd7, 8'h81, 8'h00); check("R5 rol", {flag, result}, {1'b0, 8'h03});
    apply(4'd8, 8'h81, 8'h00); check("R5 ror", {flag, result}, {1'b0, 8'hC0});
    apply(4'd7, 8'h40, 8'hFF); check("R5 rol no carry", {flag, result}, {1'b0, 8'h80});
  endtask

  task automatic testPass();
    apply(4'd0, 8'h12, 8'h9E); check("R6 pass", {flag, result}, {1'b0, 8'h9E});
    apply(4'd14, 8'h12, 8'h77); check("R10 code14", {flag, result}, {1'b0, 8'h77});
    apply(4'd15, 8'h33, 8'h33); check("R10 code15", {flag, result}, {1'b0, 8'h33});
  endtask

  task automatic testCompare();
    logic [7:0] as [4] = '{8'd5, 8'd3, 8'd200, 8'd128};
    logic [7:0] bs [4] = '{8'd5, 8'd200, 8'd3, 8'd127};
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 5; k++) begin
        logic e;
        case (k)
          0: e = (as[p] == bs[p]);
          1: e = (as[p] <  bs[p]);
          2: e = (as[p] <= bs[p]);
          3: e = (as[p] >  bs[p]);
          default: e = (as[p] >= bs[p]);
        endcase
        apply(4'(9 + k), as[p], bs[p]);
        check("R7 compare flag", {1'b0, 7'd0, flag}, {1'b0, 7'd0, e});
        check("R8 compare keeps acc", {1'b0, result}, {1'b0, as[p]});
      end
    end
    apply(4'd1, 8'd5, 8'd5);
    check("R9 no flag on add", {8'd0, flag}, 9'd0);
  endtask

  initial begin
    fork
      begin
        testInitial();
        testAddSub();
        testLogic();
        testRotate();
        testPass();
        testCompare();
      end
      begin
        while (cycles < 5000) begin @(posedge clk); cycles++; end
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule